// File: doc/BRIEF.md
# Dual-Clock Real-Time Clock Core

This block keeps wall-clock time (seconds, minutes, hours, day of month, month and year) in a slow reference clock domain. All software access goes through a small synchronous register port in a faster system clock domain. A programmable divider turns the reference clock into a one-second tick. The tick drives the calendar counters and is also brought out as a pulse in the reference domain.

Software first programs the divider and the setup time and date while the clock is stopped. It then loads the setup values into the live counters and sets the run bit. To change the time later, software clears the run bit and polls the active status bit until it reads zero. Only then does it issue a new load. The live time is returned to the system domain as a coherent snapshot. Every field of a read comes from the same reference cycle.

Top module: `rtc_core`

## Requirements
- R1: After reset, CTRL (address 0) reads 0, DIVM1 (address 1) reads 0, NOW_TIME (address 4) reads 0 and NOW_DATE (address 5) reads 0x00000101 (day 1, month 1, year 0).
- R2: The setup registers read back what was written. SET_TIME is address 2 with seconds [5:0], minutes [13:8] and hours [20:16]. SET_DATE is address 3 with day [4:0], month [11:8] and year [27:16]. The live time reads at NOW_TIME (address 4) and NOW_DATE (address 5) in the same layouts. Bits outside the fields read 0.
- R3: CTRL bit 0 (run) reaches the reference domain two reference clock edges after the system edge that stores it. While it is set there, `sec_tick` pulses high for one reference cycle every DIVM1+1 reference cycles, and each pulse follows a one-second advance. While it is clear, there are no pulses and the time does not change.
- R4: DIVM1 is 16 bits wide. Higher write bits are dropped. The reference domain takes the divider value only while counting is stopped, so a write made while running takes effect only after the next stop.
- R5: CTRL bit 1 (active, read-only) follows the run state of the reference domain through a two-flop synchroniser. It reads 0 on the read right after run is set. It still reads 1 on the read right after run is cleared. It drops to 0 within a bounded time after that.
- R6: A CTRL write with bit 4 (load) set and bit 0 clear copies SET_TIME and SET_DATE into the live time. The copy happens only when run was already clear and active reads 0. In every other case the load is ignored and the live time is unchanged.
- R7: Seconds and minutes wrap from 59 to 0 and carry. Hours wrap from 23 to 0 and carry into the day.
- R8: The day wraps to 1 after the last day of the month: 31 for months 1, 3, 5, 7, 8, 10 and 12, 30 for months 4, 6, 9 and 11, and for month 2, 29 if the year is divisible by 4 and 28 otherwise. The month wraps from 12 to 1 and increments the year.
- R9: Once counting has stopped, NOW_TIME and NOW_DATE show the frozen live time. Each read returns fields captured together through a toggle handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock for the register port |
| sys_rst_n | input | 1 | Active-low asynchronous reset, system domain |
| reg_addr | input | 3 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered: valid one cycle after reg_addr |
| ref_clk | input | 1 | Slow reference clock |
| ref_rst_n | input | 1 | Active-low asynchronous reset, reference domain |
| sec_tick | output | 1 | One-cycle pulse per elapsed second, reference domain |

## Verification
The calendar range assertions assume that software loads only valid times and dates. The stimulus only ever writes legal field values to the setup registers. The crossing of the divider and setup values assumes that these registers stay unchanged for a few reference cycles before the reference domain uses them. The bench therefore writes the divider only while stopped or well ahead of the next stop, and it waits several reference cycles between any load and the run bit. The two clocks are phase-offset so that their edges never coincide. This lets the behavioural model sample the system-side writes on each reference edge without any ordering ambiguity.

// File: rtl/rtc_core.sv
module rtc_core #(
  parameter int DIV_W  = 16,
  parameter int YEAR_W = 12
) (
  input  logic        sys_clk,
  input  logic        sys_rst_n,
  input  logic [2:0]  reg_addr,
  input  logic        reg_we,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        ref_clk,
  input  logic        ref_rst_n,
  output logic        sec_tick
);

  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_DIV  = 3'd1;
  localparam logic [2:0] A_STIM = 3'd2;
  localparam logic [2:0] A_SDAT = 3'd3;
  localparam logic [2:0] A_NTIM = 3'd4;
  localparam logic [2:0] A_NDAT = 3'd5;

  typedef struct packed {
    logic [YEAR_W-1:0] yr;
    logic [3:0]        mon;
    logic [4:0]        day;
    logic [4:0]        hr;
    logic [5:0]        min;
    logic [5:0]        sec;
  } stamp_t;

  localparam stamp_t T_RST = '{yr: '0, mon: 4'd1, day: 5'd1, hr: '0, min: '0, sec: '0};

  function automatic logic [4:0] month_len(logic [3:0] m, logic leap);
    case (m)
      4'd4, 4'd6, 4'd9, 4'd11: month_len = 5'd30;
      4'd2:                    month_len = leap ? 5'd29 : 5'd28;
      default:                 month_len = 5'd31;
    endcase
  endfunction

  function automatic stamp_t advance(stamp_t t);
    stamp_t n;
    n = t;
    if (t.sec != 6'd59) n.sec = t.sec + 6'd1;
    else begin
      n.sec = '0;
      if (t.min != 6'd59) n.min = t.min + 6'd1;
      else begin
        n.min = '0;
        if (t.hr != 5'd23) n.hr = t.hr + 5'd1;
        else begin
          n.hr = '0;
          if (t.day != month_len(t.mon, t.yr[1:0] == 2'b00)) n.day = t.day + 5'd1;
          else begin
            n.day = 5'd1;
            if (t.mon != 4'd12) n.mon = t.mon + 4'd1;
            else begin
              n.mon = 4'd1;
              n.yr  = t.yr + YEAR_W'(1);
            end
          end
        end
      end
    end
    return n;
  endfunction

  // ---------------- system domain ----------------
  logic             run_q, load_tgl, act_s1, act_s2;
  logic [DIV_W-1:0] div_q;
  stamp_t           setup_q, now_q;
  logic             tg_s1, tg_s2, ack_tgl;
  logic             ctrl_wr, load_ok;

  assign ctrl_wr = reg_we && reg_addr == A_CTRL;
  assign load_ok = ctrl_wr && reg_wdata[4] && !reg_wdata[0] && !run_q && !act_s2;

  always_ff @(posedge sys_clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      run_q    <= 1'b0;
      load_tgl <= 1'b0;
      div_q    <= '0;
      setup_q  <= T_RST;
    end else if (reg_we) begin
      case (reg_addr)
        A_CTRL: begin
          run_q <= reg_wdata[0];
          if (load_ok) load_tgl <= ~load_tgl;
        end
        A_DIV:  div_q <= reg_wdata[DIV_W-1:0];
        A_STIM: begin
          setup_q.sec <= reg_wdata[5:0];
          setup_q.min <= reg_wdata[13:8];
          setup_q.hr  <= reg_wdata[20:16];
        end
        A_SDAT: begin
          setup_q.day <= reg_wdata[4:0];
          setup_q.mon <= reg_wdata[11:8];
          setup_q.yr  <= reg_wdata[16 +: YEAR_W];
        end
        default: ;
      endcase
    end

  // ---------------- reference domain ----------------
  logic             en_s1, en_s2;
  logic             ld_s1, ld_s2, ld_s3, ld_go;
  logic             ack_s1, ack_s2, snap_tgl;
  logic [DIV_W-1:0] div_ref, cnt;
  logic             wrap;
  stamp_t           live, snap;

  assign ld_go = ld_s2 ^ ld_s3;
  assign wrap  = en_s2 && cnt == div_ref;

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      {en_s2, en_s1}         <= '0;
      {ld_s3, ld_s2, ld_s1}  <= '0;
      {ack_s2, ack_s1}       <= '0;
    end else begin
      {en_s2, en_s1}         <= {en_s1, run_q};
      {ld_s3, ld_s2, ld_s1}  <= {ld_s2, ld_s1, load_tgl};
      {ack_s2, ack_s1}       <= {ack_s1, ack_tgl};
    end

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      div_ref  <= '0;
      cnt      <= '0;
      sec_tick <= 1'b0;
    end else begin
      sec_tick <= wrap;
      if (!en_s2) begin
        div_ref <= div_q;
        cnt     <= '0;
      end else if (wrap) cnt <= '0;
      else               cnt <= cnt + DIV_W'(1);
    end

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n)             live <= T_RST;
    else if (ld_go && !en_s2)   live <= setup_q;
    else if (wrap)              live <= advance(live);

  always_ff @(posedge ref_clk or negedge ref_rst_n)
    if (!ref_rst_n) begin
      snap     <= T_RST;
      snap_tgl <= 1'b0;
    end else if (snap_tgl == ack_s2) begin
      snap     <= live;
      snap_tgl <= ~snap_tgl;
    end

  // ---------------- return path to system domain ----------------
  always_ff @(posedge sys_clk or negedge sys_rst_n)
    if (!sys_rst_n) begin
      {act_s2, act_s1} <= '0;
      {tg_s2, tg_s1}   <= '0;
      ack_tgl          <= 1'b0;
      now_q            <= T_RST;
    end else begin
      {act_s2, act_s1} <= {act_s1, en_s2};
      {tg_s2, tg_s1}   <= {tg_s1, snap_tgl};
      if (tg_s2 != ack_tgl) begin
        now_q   <= snap;
        ack_tgl <= tg_s2;
      end
    end

  always_ff @(posedge sys_clk or negedge sys_rst_n)
    if (!sys_rst_n) reg_rdata <= '0;
    else
      case (reg_addr)
        A_CTRL:  reg_rdata <= {30'd0, act_s2, run_q};
        A_DIV:   reg_rdata <= {{(32-DIV_W){1'b0}}, div_q};
        A_STIM:  reg_rdata <= {11'd0, setup_q.hr, 2'd0, setup_q.min, 2'd0, setup_q.sec};
        A_SDAT:  reg_rdata <= {{(16-YEAR_W){1'b0}}, setup_q.yr, 4'd0, setup_q.mon, 3'd0, setup_q.day};
        A_NTIM:  reg_rdata <= {11'd0, now_q.hr, 2'd0, now_q.min, 2'd0, now_q.sec};
        A_NDAT:  reg_rdata <= {{(16-YEAR_W){1'b0}}, now_q.yr, 4'd0, now_q.mon, 3'd0, now_q.day};
        default: reg_rdata <= '0;
      endcase

  // ---------------- assertions ----------------
  AST_TICK_SINGLE: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (sec_tick && div_ref != '0) |=> !sec_tick); // R3

  AST_CNT_BOUND: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    en_s2 |-> cnt <= div_ref); // R4

  AST_DIV_HELD: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (en_s2 && en_s1) |=> $stable(div_ref)); // R4

  AST_FROZEN_OFF: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (!en_s2 && !ld_go) |=> $stable(live)); // R3

  AST_TIME_VALID: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    live.sec < 6'd60 && live.min < 6'd60 && live.hr < 5'd24 &&
    live.mon >= 4'd1 && live.mon <= 4'd12 && live.day >= 5'd1); // R7

  AST_SEC_STEP: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (wrap && live.sec != 6'd59) |=> live.sec == $past(live.sec) + 6'd1); // R7

  AST_LOAD_GATED: assert property (@(posedge sys_clk) disable iff (!sys_rst_n)
    (load_tgl != $past(load_tgl)) |-> ($past(!run_q) && $past(!act_s2))); // R6

endmodule

// File: tb/rtc_core_tb_top.sv
module rtc_core_tb_top;
  logic        sys_clk = 1'b0, ref_clk = 1'b0;
  logic        sys_rst_n = 1'b0, ref_rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_we = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        sec_tick;

  int total = 0, bad = 0;
  bit done = 0;

  rtc_core dut_i (
    .sys_clk(sys_clk), .sys_rst_n(sys_rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ref_clk(ref_clk),
    .ref_rst_n(ref_rst_n), .sec_tick(sec_tick));

  always #10 sys_clk = ~sys_clk;
  initial begin
    #3;
    forever #35 ref_clk = ~ref_clk;
  end

  task automatic chk(bit ok, string req, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
    end
  endtask

  // system-side mirror of what software has written
  bit en_m = 0;
  int div_m = 0;
  always @(posedge sys_clk)
    if (sys_rst_n && reg_we) begin
      if (reg_addr == 3'd0) en_m <= reg_wdata[0];
      if (reg_addr == 3'd1) div_m <= int'(reg_wdata[15:0]);
    end

  // behavioural model of the reference domain
  int m_sec = 0, m_min = 0, m_hr = 0, m_day = 1, m_mon = 1, m_yr = 0;
  int m_cnt = 0, m_div = 0;
  bit exp_tick = 0;
  bit en_hist[$] = '{0, 0};

  function automatic int days_in(int m, int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic one_second();
    m_sec++;
    if (m_sec == 60) begin m_sec = 0; m_min++; end
    if (m_min == 60) begin m_min = 0; m_hr++; end
    if (m_hr == 24) begin m_hr = 0; m_day++; end
    if (m_day > days_in(m_mon, m_yr)) begin m_day = 1; m_mon++; end
    if (m_mon == 13) begin m_mon = 1; m_yr = (m_yr + 1) % 4096; end
  endtask

  always @(posedge ref_clk)
    if (!ref_rst_n) begin
      en_hist = '{0, 0};
      m_cnt = 0; exp_tick = 0;
    end else begin
      bit eff;
      en_hist.push_front(en_m);
      eff = en_hist[2];
      en_hist.pop_back();
      if (eff) begin
        if (m_cnt == m_div) begin m_cnt = 0; exp_tick = 1; one_second(); end
        else begin m_cnt++; exp_tick = 0; end
      end else begin
        m_cnt = 0; exp_tick = 0; m_div = div_m;
      end
    end

  always @(negedge ref_clk)
    if (ref_rst_n && !done) chk(sec_tick === exp_tick, "R3 sec_tick", sec_tick, exp_tick);

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge sys_clk);
    reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge sys_clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge sys_clk);
    reg_addr = a;
    @(negedge sys_clk);
    d = reg_rdata;
  endtask

  task automatic wait_ref(int n);
    repeat (n) @(posedge ref_clk);
  endtask

  task automatic chk_now(string req);
    logic [31:0] t, d;
    rd(3'd4, t);
    rd(3'd5, d);
    chk(t == 32'(m_sec | (m_min << 8) | (m_hr << 16)), {req, " NOW_TIME"}, t,
        m_sec | (m_min << 8) | (m_hr << 16));
    chk(d == 32'(m_day | (m_mon << 8) | (m_yr << 16)), {req, " NOW_DATE"}, d,
        m_day | (m_mon << 8) | (m_yr << 16));
  endtask

  task automatic load(int s, int mi, int h, int dy, int mo, int y);
    wr(3'd2, 32'(s | (mi << 8) | (h << 16)));
    wr(3'd3, 32'(dy | (mo << 8) | (y << 16)));
    wr(3'd0, 32'h10);
    m_sec = s; m_min = mi; m_hr = h; m_day = dy; m_mon = mo; m_yr = y;
    wait_ref(12);
    chk_now("R6 load");
  endtask

  task automatic start();
    logic [31:0] v;
    wr(3'd0, 32'h1);
    rd(3'd0, v);
    chk(v == 32'h1, "R5 active low after run set", v, 1);
  endtask

  task automatic stop(bit try_load);
    logic [31:0] v;
    wr(3'd0, 32'h0);
    if (try_load) wr(3'd0, 32'h10);
    rd(3'd0, v);
    chk(v == 32'h2, "R5 active high after run clear", v, 2);
    for (int i = 0; i < 60; i++) begin
      rd(3'd0, v);
      if (!v[1]) break;
    end
    chk(v == 32'h0, "R5 active dropped", v, 0);
    wait_ref(12);
  endtask

  initial begin
    #(200000 * 20);
    if (!done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    #200;
    sys_rst_n = 1'b1;
    ref_rst_n = 1'b1;
    wait_ref(3);

    rd(3'd0, v); chk(v == 32'h0, "R1 CTRL reset", v, 0);
    rd(3'd1, v); chk(v == 32'h0, "R1 DIVM1 reset", v, 0);
    rd(3'd4, v); chk(v == 32'h0, "R1 NOW_TIME reset", v, 0);
    rd(3'd5, v); chk(v == 32'h101, "R1 NOW_DATE reset", v, 32'h101);

    wr(3'd1, 32'h1_2345);
    rd(3'd1, v); chk(v == 32'h2345, "R4 divider width", v, 32'h2345);
    wr(3'd1, 32'd3);

    load(58, 59, 23, 28, 2, 3);
    rd(3'd2, v); chk(v == 32'h00173B3A, "R2 SET_TIME readback", v, 32'h00173B3A);
    rd(3'd3, v); chk(v == 32'h0003021C, "R2 SET_DATE readback", v, 32'h0003021C);

    start();
    wait_ref(40);
    rd(3'd0, v); chk(v == 32'h3, "R5 active while running", v, 3);
    wr(3'd2, 32'h0);
    wr(3'd3, 32'h00050101);
    wr(3'd0, 32'h11);
    wr(3'd1, 32'd1);
    rd(3'd1, v); chk(v == 32'h1, "R4 divider readback while running", v, 1);
    wait_ref(30);
    stop(1);
    chk_now("R6 R7 R8 R9 ignored loads, non-leap rollover");

    load(59, 59, 23, 28, 2, 4);
    start();
    wait_ref(10);
    stop(0);
    chk_now("R8 leap February");

    wr(3'd1, 32'd0);
    load(59, 59, 23, 31, 12, 7);
    start();
    wait_ref(5);
    stop(0);
    chk_now("R8 year rollover");

    load(50, 59, 23, 30, 4, 9);
    start();
    wait_ref(20);
    stop(0);
    chk_now("R8 thirty-day month");

    load(59, 58, 10, 15, 6, 9);
    start();
    wait_ref(70);
    stop(0);
    chk_now("R7 minute and hour carry");

    wr(3'd1, 32'd2);
    start();
    wait_ref(25);
    stop(0);
    chk_now("R4 R9 new divider after stop");

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule